// File: doc/BRIEF.md
# Keyed Clock-Control Register Bank

This block is the software-visible register file of a clock manager. It spans a 512-byte window of 128 words. Each clock channel owns two adjacent words: a control word (source select, enable, kill, gate and mode flags) and a divisor word (a 12-bit integer part and a 12-bit fraction). A short range of oscillator and PLL status words sits in the same window. Those words always read back as all ones. The block exports each channel's fields as ports, so that clock generators elsewhere can use them. The clock generators themselves are not part of this block.

Writes are protected by a key. A write is accepted only when the top byte of the write data carries the key value 0x5A. The key byte is then cleared before the word is stored. A write with any other top byte leaves every register untouched. Only some channel indices are implemented. Those channels come out of reset enabled, sourced from the oscillator, and dividing by one. Every other word resets to zero.

Reads and writes use separate ports, so both can occur in one cycle. Read data is registered. It appears one cycle after the request and holds until the next read.

Top module: `clkreg_bank`

## Requirements
- R1: After reset, each implemented channel n has its control word (byte offset 8n) equal to 0x00000011, which means source 1 and enable bit 4 set. Its divisor word (byte offset 8n+4) equals 0x00001000, which means integer 1 and fraction 0.
- R2: After reset, every word that is neither an implemented channel word nor a status word reads 0x00000000.
- R3: A write whose data bits 31:24 equal 0x5A stores the data with bits 31:24 forced to zero. A later read of that word returns the stored value.
- R4: A write whose data bits 31:24 differ from 0x5A changes no register and no exported field.
- R5: A read of any word at byte offsets 0x100 through 0x118, or at 0x170, returns 0xFFFFFFFF. This holds regardless of what was written there.
- R6: For an implemented channel n, the exported fields come from its stored words, as follows:
  - source comes from control bits 3:0;
  - enable comes from control bit 4;
  - kill comes from control bit 5;
  - gate comes from control bit 6;
  - fraction comes from divisor bits 11:0;
  - integer comes from divisor bits 23:12.
- R7: Read data is registered on the clock edge that samples rd_en. It holds its value in all cycles without rd_en.
- R8: When a read and an accepted write hit the same non-status word in the same cycle, the read returns the value held before the write. The next read returns the new value.
- R9: The implemented channel indices are 0–22, 24–31, 43–45, 50 and 53–56. For every other index, the exported fields are zero, even after keyed writes to its words.
- R10: Address bits 1:0 are ignored on both ports. Every access addresses a whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 9 | Write byte address |
| wr_data | input | 32 | Write data; bits 31:24 carry the key |
| rd_en | input | 1 | Read request |
| rd_addr | input | 9 | Read byte address |
| rd_data | output | 32 | Registered read data |
| ch_src | output | 256 | Source select, 4 bits per channel |
| ch_enable | output | 64 | Enable, 1 bit per channel |
| ch_kill | output | 64 | Kill, 1 bit per channel |
| ch_gate | output | 64 | Gate, 1 bit per channel |
| ch_div_int | output | 768 | Divisor integer part, 12 bits per channel |
| ch_div_frac | output | 768 | Divisor fraction, 12 bits per channel |

## Verification
A read and a keyed write can land on the same word in the same cycle. The bench provokes this by raising both ports in one cycle, with the same address and fresh keyed data. It judges the result in two steps:
- the registered read data must still show the earlier contents;
- a following read must show the new value with the key byte cleared.

The key check is swept across every word with wrong key bytes. Each word is then read back, and the outputs must be unchanged.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
    localparam int WORD_W    = 32;
    localparam int WIN_BYTES = 512;
    localparam int NWORDS    = WIN_BYTES / (WORD_W / 8);
    localparam int NCHAN     = NWORDS / 2;
    localparam int AW        = $clog2(WIN_BYTES);
    localparam int IDX_W     = $clog2(NWORDS);
    localparam int KEY_W     = 8;
    localparam int SRC_W     = 4;
    localparam int DIV_W     = 12;
    localparam int EN_BIT    = 4;
    localparam int KILL_BIT  = 5;
    localparam int GATE_BIT  = 6;
    localparam logic [WORD_W-1:0] CTL_RESET = (32'd1 << EN_BIT) | 32'd1;
    localparam logic [WORD_W-1:0] DIV_RESET = 32'd1 << DIV_W;

    typedef logic [NWORDS-1:0][WORD_W-1:0] regfile_t;

    typedef struct packed {
        regfile_t          mem;
        logic [WORD_W-1:0] rdata;
    } state_t;

    function automatic logic chan_valid(input int n);
        return (n >= 0 && n <= 22) || (n >= 24 && n <= 31) ||
               (n >= 43 && n <= 45) || (n == 50) || (n >= 53 && n <= 56);
    endfunction

    function automatic logic status_word(input int w);
        int b;
        b = w * 4;
        return (b >= 256 && b <= 280) || (b == 368);
    endfunction

    function automatic regfile_t reset_image();
        regfile_t img;
        img = '0;
        for (int c = 0; c < NCHAN; c++) begin
            if (chan_valid(c)) begin
                img[2*c]   = CTL_RESET;
                img[2*c+1] = DIV_RESET;
            end
        end
        return img;
    endfunction
endpackage

// File: rtl/clkreg_keygate.sv
module clkreg_keygate
    import clkreg_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 8'h5A
) (
    input  logic [WORD_W-1:0] data_in,
    output logic              key_ok,
    output logic [WORD_W-1:0] data_clean
);
    always_comb begin
        key_ok     = (data_in[WORD_W-1 -: KEY_W] == KEY);
        data_clean = {{KEY_W{1'b0}}, data_in[WORD_W-KEY_W-1:0]};
    end
endmodule

// File: rtl/clkreg_decode.sv
module clkreg_decode
    import clkreg_pkg::*;
(
    input  logic [AW-1:0]    byte_addr,
    output logic [IDX_W-1:0] word_idx,
    output logic             is_status
);
    always_comb begin
        word_idx  = byte_addr[AW-1:2];
        is_status = status_word(int'(word_idx));
    end
endmodule

// File: rtl/clkreg_export.sv
module clkreg_export
    import clkreg_pkg::*;
(
    input  regfile_t                 mem,
    output logic [NCHAN*SRC_W-1:0]   ch_src,
    output logic [NCHAN-1:0]         ch_enable,
    output logic [NCHAN-1:0]         ch_kill,
    output logic [NCHAN-1:0]         ch_gate,
    output logic [NCHAN*DIV_W-1:0]   ch_div_int,
    output logic [NCHAN*DIV_W-1:0]   ch_div_frac
);
    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        if (chan_valid(g)) begin : g_live
            assign ch_src[g*SRC_W +: SRC_W]      = mem[2*g][SRC_W-1:0];
            assign ch_enable[g]                  = mem[2*g][EN_BIT];
            assign ch_kill[g]                    = mem[2*g][KILL_BIT];
            assign ch_gate[g]                    = mem[2*g][GATE_BIT];
            assign ch_div_frac[g*DIV_W +: DIV_W] = mem[2*g+1][DIV_W-1:0];
            assign ch_div_int[g*DIV_W +: DIV_W]  = mem[2*g+1][2*DIV_W-1:DIV_W];
        end else begin : g_dead
            assign ch_src[g*SRC_W +: SRC_W]      = '0;
            assign ch_enable[g]                  = 1'b0;
            assign ch_kill[g]                    = 1'b0;
            assign ch_gate[g]                    = 1'b0;
            assign ch_div_frac[g*DIV_W +: DIV_W] = '0;
            assign ch_div_int[g*DIV_W +: DIV_W]  = '0;
        end
    end
endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
    import clkreg_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     rd_en,
    input  logic [AW-1:0]            rd_addr,
    output logic [WORD_W-1:0]        rd_data,
    output logic [NCHAN*SRC_W-1:0]   ch_src,
    output logic [NCHAN-1:0]         ch_enable,
    output logic [NCHAN-1:0]         ch_kill,
    output logic [NCHAN-1:0]         ch_gate,
    output logic [NCHAN*DIV_W-1:0]   ch_div_int,
    output logic [NCHAN*DIV_W-1:0]   ch_div_frac
);
    state_t            state_d, state_q;
    logic              key_ok;
    logic [WORD_W-1:0] wr_clean;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic              wr_is_status, rd_is_status;

    clkreg_keygate #(.KEY(KEY)) u_key (
        .data_in    (wr_data),
        .key_ok     (key_ok),
        .data_clean (wr_clean)
    );

    clkreg_decode u_wr_dec (
        .byte_addr (wr_addr),
        .word_idx  (wr_idx),
        .is_status (wr_is_status)
    );

    clkreg_decode u_rd_dec (
        .byte_addr (rd_addr),
        .word_idx  (rd_idx),
        .is_status (rd_is_status)
    );

    always_comb begin
        state_d = state_q;
        if (rd_en) begin
            state_d.rdata = rd_is_status ? '1 : state_q.mem[rd_idx];
        end
        if (wr_en && key_ok) begin
            state_d.mem[wr_idx] = wr_clean;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mem   <= reset_image();
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data = state_q.rdata;

    clkreg_export u_export (
        .mem         (state_q.mem),
        .ch_src      (ch_src),
        .ch_enable   (ch_enable),
        .ch_kill     (ch_kill),
        .ch_gate     (ch_gate),
        .ch_div_int  (ch_div_int),
        .ch_div_frac (ch_div_frac)
    );

    AST_KEY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_ok) |=> (state_q.mem[$past(wr_idx)] ==
                               {{KEY_W{1'b0}}, $past(wr_data[WORD_W-KEY_W-1:0])})); // R3
    AST_KEY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_ok) |=> $stable(state_q.mem)); // R4
    AST_STATUS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_is_status) |=> (rd_data == '1)); // R5
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R7
    AST_COLLIDE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && key_ok && !rd_is_status && rd_idx == wr_idx)
        |=> (rd_data == $past(state_q.mem[rd_idx]))); // R8
endmodule

// File: tb/clkreg_bank_tb.sv
module clkreg_bank_tb;
    import clkreg_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   wr_en = 1'b0;
    logic [AW-1:0]          wr_addr = '0;
    logic [WORD_W-1:0]      wr_data = '0;
    logic                   rd_en = 1'b0;
    logic [AW-1:0]          rd_addr = '0;
    logic [WORD_W-1:0]      rd_data;
    logic [NCHAN*SRC_W-1:0] ch_src;
    logic [NCHAN-1:0]       ch_enable, ch_kill, ch_gate;
    logic [NCHAN*DIV_W-1:0] ch_div_int, ch_div_frac;

    int tests = 0;
    int fails = 0;
    logic [31:0] model [128];

    always #4 clk = ~clk;

    clkreg_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ch_src(ch_src), .ch_enable(ch_enable), .ch_kill(ch_kill), .ch_gate(ch_gate),
        .ch_div_int(ch_div_int), .ch_div_frac(ch_div_frac)
    );

    function automatic bit tb_live(input int n);
        return (n <= 22) || (n >= 24 && n <= 31) || (n >= 43 && n <= 45) ||
               (n == 50) || (n >= 53 && n <= 56);
    endfunction

    function automatic bit tb_status(input int w);
        return (w >= 64 && w <= 70) || (w == 92);
    endfunction

    function automatic logic [31:0] tb_expect_read(input int w);
        return tb_status(w) ? 32'hFFFF_FFFF : model[w];
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic sweep_read(input string req);
        logic [31:0] v;
        for (int w = 0; w < 128; w++) begin
            bus_read(AW'(w * 4), v);
            check(req, v, tb_expect_read(w), $sformatf("word %0d", w));
        end
    endtask

    task automatic check_exports(input string req);
        for (int c = 0; c < 64; c++) begin
            logic [31:0] ctl, dv;
            ctl = tb_live(c) ? model[2*c]   : 32'h0;
            dv  = tb_live(c) ? model[2*c+1] : 32'h0;
            check(req, {28'h0, ch_src[c*4 +: 4]}, {28'h0, ctl[3:0]}, $sformatf("src ch%0d", c));
            check(req, {29'h0, ch_gate[c], ch_kill[c], ch_enable[c]},
                  {29'h0, ctl[6:4]}, $sformatf("en/kill/gate ch%0d", c));
            check(req, {20'h0, ch_div_frac[c*12 +: 12]}, {20'h0, dv[11:0]}, $sformatf("frac ch%0d", c));
            check(req, {20'h0, ch_div_int[c*12 +: 12]}, {20'h0, dv[23:12]}, $sformatf("int ch%0d", c));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int w = 0; w < 128; w++) model[w] = 32'h0;
        for (int c = 0; c < 64; c++) begin
            if (tb_live(c)) begin
                model[2*c]   = 32'h0000_0011;
                model[2*c+1] = 32'h0000_1000;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", rd_data, 32'h0, "rd_data after reset");

        // R1 R2 R5: reset image over the whole window
        sweep_read("R1/R2/R5 reset");
        // R1 R9: exported fields after reset
        check_exports("R9 reset exports");

        // R3 R5 R6 R9: keyed writes to every word
        for (int w = 0; w < 128; w++) begin
            logic [23:0] pat;
            pat = 24'(w * 32'h0001_0307) ^ 24'hA5_C3_96;
            bus_write(AW'(w * 4), {8'h5A, pat});
            model[w] = {8'h00, pat};
        end
        sweep_read("R3/R5 keyed");
        check_exports("R6/R9 keyed");

        // R4: wrong key bytes leave everything as it was
        for (int w = 0; w < 128; w++) begin
            logic [7:0] bad;
            bad = 8'h5A ^ 8'(w + 1);
            bus_write(AW'(w * 4), {bad, 24'h0F0F0F});
        end
        bus_write(9'h008, 32'h5B00_0000);
        bus_write(9'h00C, 32'hDA12_3456);
        sweep_read("R4 bad key");
        check_exports("R4 exports unchanged");

        // R10: low address bits ignored on both ports
        bus_write(9'h00B, 32'h5A00_0075);
        model[2] = 32'h0000_0075;
        bus_read(9'h009, v);
        check("R10", v, 32'h0000_0075, "offset-ignored read");
        check("R6", {29'h0, ch_gate[1], ch_kill[1], ch_enable[1]}, 32'h7, "ch1 bits");
        check("R6", {28'h0, ch_src[4 +: 4]}, 32'h5, "ch1 src");

        // R7: rd_data holds across cycles without a read
        bus_read(9'h010, v);
        bus_write(9'h010, 32'h5A00_0ABC);
        model[4] = 32'h0000_0ABC;
        bus_write(9'h014, 32'h5A00_1DEF);
        model[5] = 32'h0000_1DEF;
        @(negedge clk);
        check("R7", rd_data, v, "held read data");

        // R8: same-cycle read and keyed write to one word
        wr_en = 1'b1; wr_addr = 9'h020; wr_data = 32'h5A77_7777;
        rd_en = 1'b1; rd_addr = 9'h020;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R8", rd_data, model[8], "collision returns old");
        model[8] = 32'h0077_7777;
        bus_read(9'h020, v);
        check("R8", v, 32'h0077_7777, "next read returns new");

        // R5: collision on a status word still reads ones
        wr_en = 1'b1; wr_addr = 9'h170; wr_data = 32'h5A00_0001;
        rd_en = 1'b1; rd_addr = 9'h170;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R5", rd_data, 32'hFFFF_FFFF, "status under write");

        // R9: invalid channel 23 stored but not exported
        bus_write(9'h0B8, 32'h5A00_007F);
        model[46] = 32'h0000_007F;
        bus_read(9'h0B8, v);
        check("R9", v, 32'h0000_007F, "ch23 stored");
        check("R9", {28'h0, ch_src[23*4 +: 4], ch_enable[23]}, 32'h0, "ch23 not exported");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule